// File: doc/BRIEF.md
# Packed Byte Dot Product Accumulator

This execution unit takes two 32-bit words that each hold packed 8-bit lanes and forms their integer dot product. It then adds a 32-bit accumulate operand to that sum. A mode bit sets the vector length. With two lanes, a half-select bit picks either the low or the high 16 bits of each source. With four lanes, all four bytes of each source are used. A signedness control picks between two readings of the bytes. In the first, both vectors are unsigned. In the second, the first source's bytes are signed and the second source's bytes are unsigned. The accumulate operand can be negated before the add. The result can be saturated or left to wrap.

An issue strobe presents one operation. The unit returns the result together with a valid flag on the next clock edge. Operand fetch and register write-back belong to the surrounding pipeline.

Top module: `dot8_acc`

## Requirements
- R1: After reset, `res_valid` is 0. From then on, `res_valid` equals `issue` as sampled at the previous rising clock edge.
- R2: When `vec4` = 1, the four byte lanes of each source are used. Lane k occupies bits 8k+7:8k.
- R3: When `vec4` = 0, two lanes are used. If `half_hi` = 0 they come from bits 15:0; if `half_hi` = 1 they come from bits 31:16. Lane 0 is the lower byte of the selected half.
- R4: When `mixed` = 0, the bytes of both sources are unsigned. When `mixed` = 1, the bytes of `src_a` are two's-complement signed and the bytes of `src_b` are unsigned.
- R5: The exact sum is computed as dot product + `src_c`. `src_c` is read as signed when `mixed` = 1 and as unsigned when `mixed` = 0. When `neg_c` = 1, `src_c` is negated before the add.
- R6: When `sat` = 0, the result is the exact sum modulo 2^32.
- R7: When `sat` = 1 and `mixed` = 1, the result is clamped to the range -2^31 to 2^31-1.
- R8: When `sat` = 1 and `mixed` = 0, the result is clamped to the range 0 to 0xFFFFFFFF.
- R9: `result` changes only on a clock edge where `issue` is 1. Otherwise it holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation strobe |
| vec4 | input | 1 | 1: four lanes, 0: two lanes |
| mixed | input | 1 | 1: signed A bytes times unsigned B bytes |
| half_hi | input | 1 | Two-lane half select |
| neg_c | input | 1 | Negate the accumulate operand |
| sat | input | 1 | Saturate instead of wrapping |
| src_a | input | 32 | Packed first vector |
| src_b | input | 32 | Packed second vector |
| src_c | input | 32 | Accumulate operand |
| result | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after issue |

## Verification
Every result is due exactly one rising edge after the edge that sampled `issue`. The bench drives its inputs on falling edges. On each falling edge it compares the outputs against a reference value that it queued at the preceding rising edge, so every comparison lands in the cycle the result appears. Idle cycles are compared the same way: the expected value is the held result with the valid flag low.

// File: rtl/dot8_acc.sv
module dot8_acc #(
  parameter int W = 32,
  parameter int LANE = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic         vec4,
  input  logic         mixed,
  input  logic         half_hi,
  input  logic         neg_c,
  input  logic         sat,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] src_c,
  output logic [W-1:0] result,
  output logic         res_valid
);
  localparam int NL = W / LANE;
  localparam int XW = W + 2;

  logic [W-1:0] a_sel, b_sel;
  assign a_sel = vec4 ? src_a : (half_hi ? {{(W/2){1'b0}}, src_a[W-1:W/2]} : {{(W/2){1'b0}}, src_a[W/2-1:0]});
  assign b_sel = vec4 ? src_b : (half_hi ? {{(W/2){1'b0}}, src_b[W-1:W/2]} : {{(W/2){1'b0}}, src_b[W/2-1:0]});

  logic signed [XW-1:0] prod [NL];
  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic signed [LANE:0] ax, bx;
    assign ax = {mixed & a_sel[k*LANE+LANE-1], a_sel[k*LANE +: LANE]};
    assign bx = {1'b0, b_sel[k*LANE +: LANE]};
    assign prod[k] = XW'(ax * bx);
  end

  logic signed [XW-1:0] cx, sum;
  assign cx = {{2{mixed & src_c[W-1]}}, src_c};

  always_comb begin
    sum = neg_c ? -cx : cx;
    for (int k = 0; k < NL; k++) sum = sum + prod[k];
  end

  localparam logic signed [XW-1:0] SMAX = XW'((64'sd1 <<< (W-1)) - 1);
  localparam logic signed [XW-1:0] SMIN = -XW'(64'sd1 <<< (W-1));
  localparam logic signed [XW-1:0] UMAX = XW'((64'sd1 <<< W) - 1);

  logic [W-1:0] nxt;
  always_comb begin
    nxt = sum[W-1:0];
    if (sat) begin
      if (mixed) begin
        if (sum > SMAX) nxt = SMAX[W-1:0];
        else if (sum < SMIN) nxt = SMIN[W-1:0];
      end else begin
        if (sum < 0) nxt = '0;
        else if (sum > UMAX) nxt = UMAX[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= issue;
      if (issue) result <= nxt;
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_valid == $past(issue));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(result));
  p_unsigned_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && sat && !mixed && !neg_c) |=> result >= $past(src_c));
  p_zero_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !sat && !neg_c && src_b == '0) |=> result == $past(src_c));
  p_vec2_upper_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !vec4 && !half_hi && !sat && !neg_c && src_b[W/2-1:0] == '0) |=> result == $past(src_c));
endmodule

// File: tb/dot8_acc_tb.sv
module dot8_acc_tb;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, issue = 0, vec4 = 0, mixed = 0, half_hi = 0, neg_c = 0, sat = 0;
  logic [31:0] src_a = 0, src_b = 0, src_c = 0;
  logic [31:0] result;
  logic res_valid;
  int checks = 0, errors = 0;
  logic [31:0] exp_res = 0;
  logic exp_v = 0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  dot8_acc u_dut (.clk, .rst_n, .issue, .vec4, .mixed, .half_hi, .neg_c, .sat,
    .src_a, .src_b, .src_c, .result, .res_valid);

  function automatic logic [31:0] model(logic v4, logic mx, logic hh, logic nc, logic st,
                                        logic [31:0] a, logic [31:0] b, logic [31:0] c);
    longint s, ai, bi;
    int n = v4 ? 4 : 2;
    int base = (!v4 && hh) ? 16 : 0;
    s = mx ? longint'($signed(c)) : longint'(c);
    if (nc) s = -s;
    for (int k = 0; k < n; k++) begin
      ai = a[base+8*k +: 8];
      if (mx && ai > 127) ai -= 256;
      bi = b[base+8*k +: 8];
      s += ai * bi;
    end
    if (st && mx) begin
      if (s > 64'sd2147483647) s = 64'sd2147483647;
      if (s < -64'sd2147483648) s = -64'sd2147483648;
    end else if (st) begin
      if (s < 0) s = 0;
      if (s > 64'sd4294967295) s = 64'sd4294967295;
    end
    return s[31:0];
  endfunction

  always @(posedge clk) if (rst_n) begin
    exp_v <= issue;
    if (issue) exp_res <= model(vec4, mixed, half_hi, neg_c, sat, src_a, src_b, src_c);
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (result !== exp_res || res_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: result=%h valid=%b expected %h valid=%b", tag, result, res_valid, exp_res, exp_v);
    end
  end

  task automatic op(string t, logic v4, logic mx, logic hh, logic nc, logic st,
                    logic [31:0] a, logic [31:0] b, logic [31:0] c);
    @(negedge clk);
    tag = t; issue = 1; vec4 = v4; mixed = mx; half_hi = hh; neg_c = nc; sat = st;
    src_a = a; src_b = b; src_c = c;
  endtask

  task automatic idle(string t, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tag = t; issue = 0; src_a = $urandom; src_b = $urandom; src_c = $urandom;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*2+1);
    checks++;
    if (res_valid !== 0 || result !== 0) begin
      errors++;
      $display("FAIL R1: reset valid=%b result=%h expected 0 0", res_valid, result);
    end
    @(negedge clk); rst_n = 1;
    idle("R1", 2);
    op("R2", 1, 0, 0, 0, 0, 32'h04030201, 32'h01010101, 32'd100);
    op("R2", 1, 0, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0);
    op("R3", 0, 0, 0, 0, 0, 32'hAABB0302, 32'hCCDD0505, 32'd0);
    op("R3", 0, 0, 1, 0, 0, 32'h0302AABB, 32'h0505CCDD, 32'd7);
    op("R4", 1, 1, 0, 0, 0, 32'h80FF7F01, 32'hFFFFFFFF, 32'd0);
    op("R4", 0, 1, 1, 0, 0, 32'hFE800000, 32'h02030000, 32'hFFFFFFF0);
    op("R5", 1, 0, 0, 1, 0, 32'h01010101, 32'h02020202, 32'd3);
    op("R5", 1, 1, 0, 1, 0, 32'h01010101, 32'h01010101, 32'h80000000);
    op("R6", 1, 0, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R7", 1, 1, 0, 0, 1, 32'h7F7F7F7F, 32'hFFFFFFFF, 32'h7FFFFFFF);
    op("R7", 1, 1, 0, 0, 1, 32'h80808080, 32'hFFFFFFFF, 32'h80000000);
    op("R7", 1, 1, 0, 1, 1, 32'h0, 32'h0, 32'h80000000);
    op("R8", 1, 0, 0, 0, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    op("R8", 0, 0, 0, 1, 1, 32'h00000101, 32'h00000101, 32'd50);
    idle("R9", 3);
    op("R9", 0, 0, 0, 0, 0, 32'h0101, 32'h0202, 32'd1);
    idle("R9", 2);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      tag = "R6"; issue = ($urandom % 4) != 0; vec4 = $urandom; mixed = $urandom;
      half_hi = $urandom; neg_c = $urandom; sat = $urandom;
      src_a = $urandom; src_b = $urandom; src_c = $urandom;
    end
    idle("R1", 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule